// File: doc/BRIEF.md
# Chainable Event Counter Pair

This block is a small performance-monitor unit built around a pair of 64-bit event counters, an even one (index 0) and an odd one (index 1). Each counter picks its event source from a per-counter event-type byte: an external pulse input, a software-increment strobe, or, for the odd counter only, overflows of its even neighbour. Software controls the unit through a flat register interface with a one-cycle write port and a combinational read port.

A long-counter mode bit in the control register sets where a counter overflows. With the bit clear, the overflow point is the wrap of the low 32 bits. The full 64-bit value keeps counting, and the odd counter can be chained so that the pair behaves as one wider counter. With the bit set, overflow happens only at the full 64-bit wrap, and chaining is turned off. Each overflow sets a sticky status bit. These bits are cleared by writing 1. A level interrupt output combines the status bits with per-counter interrupt enables.

Register addresses (4-bit): 0 control, 1 enable-set, 2 enable-clear, 3 overflow status, 4 interrupt-enable set, 5 interrupt-enable clear, 6 software increment, 8+i counter i value, 12+i counter i event type. Reading 1/2 returns the enable mask, reading 4/5 returns the interrupt-enable mask, reading 3 returns the status bits, and reading 6 returns 0.

Top module: `evp_pair_pmu`

## Requirements
- R1: After reset every counter, enable, interrupt enable, status bit and event type reads 0. The control register reads with only its read-only field at bits 15:11 non-zero. That field holds the number of counters (2, giving 0x1000) and ignores writes.
- R2: Control bit 1 (clear all event counters) and bit 2 (cycle reset) take effect on the write only and read back as 0. Bits 0 and 3 to 7 keep their written values. Writing bit 1 as 1 sets both counters to 0.
- R3: A counter increments only when control bit 0 (global enable) and its own enable bit are both set. Writing 1s to address 1 sets enable bits, and writing 1s to address 2 clears them.
- R4: With control bit 7 clear, a counter flags overflow when its low 32 bits step from 0xFFFFFFFF to 0. Its upper 32 bits still carry. A step from 0xFFFFFFFE flags nothing.
- R5: With control bit 7 set, a counter flags overflow only when the full 64-bit value steps from all ones to 0. A low-32 wrap flags nothing.
- R6: With control bit 7 clear and the odd counter's type set to chain, the odd counter increments once per even-counter overflow. If that step wraps the odd counter too, both status bits are set (status 0b11).
- R7: With control bit 7 set, a chain-type odd counter never changes through counting, even when the even counter overflows.
- R8: A status bit is set by its counter's overflow whatever the interrupt enables are, and stays set until a 1 is written to that bit at address 3. Writing 0 leaves it unchanged.
- R9: The interrupt output is the OR over the counters of (status AND interrupt enable). It is a level output that holds until the status or enable is cleared. Address 4 sets interrupt enables, and address 5 clears them.
- R10: Writing a 1 in bit i of address 6 increments counter i by one only when the global enable is set, counter i is enabled, and its type is software increment. Otherwise the write is ignored.
- R11: Event-type codes are 0x00 software increment, 0x1E chain and 0x13 external pulse (ev_pulse[i]). Any other code counts nothing, and the even counter treats chain as counting nothing.
- R12: A register write to a counter in the same cycle as an increment of that counter loads the written value and flags no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe, one cycle |
| wr_addr | input | 4 | Register write address |
| wr_data | input | 64 | Register write data |
| rd_addr | input | 4 | Register read address |
| rd_data | output | 64 | Combinational read data |
| ev_pulse | input | 2 | External event pulse per counter |
| irq | output | 1 | Level overflow interrupt |

## Verification
The counting path is driven through a table of cases that crosses the mode bit with the odd counter's type: chain with a plain even overflow, chain where the carry also wraps the odd counter, the same two presets under long mode, an external type and an unused code. Comparing the counter values and status across these cases separates a wrong overflow point, chaining that leaks into long mode, and a decode that counts on the wrong code. Directed cases then cover the exact 32-bit boundary, the one-shot control bits, software increments under each gate, sticky status with a masked interrupt, and a write colliding with a pulse.

// File: rtl/evp_pkg.sv
package evp_pkg;
   localparam int REG_AW = 4;

   localparam logic [REG_AW-1:0] A_CTRL   = 4'd0;
   localparam logic [REG_AW-1:0] A_ENSET  = 4'd1;
   localparam logic [REG_AW-1:0] A_ENCLR  = 4'd2;
   localparam logic [REG_AW-1:0] A_OVS    = 4'd3;
   localparam logic [REG_AW-1:0] A_INTSET = 4'd4;
   localparam logic [REG_AW-1:0] A_INTCLR = 4'd5;
   localparam logic [REG_AW-1:0] A_SWINC  = 4'd6;
   localparam logic [REG_AW-1:0] A_CNT0   = 4'd8;
   localparam logic [REG_AW-1:0] A_TYP0   = 4'd12;

   localparam int MAX_CNT = 4;

   localparam logic [7:0] EV_SWINC = 8'h00;
   localparam logic [7:0] EV_CHAIN = 8'h1E;
   localparam logic [7:0] EV_EXT   = 8'h13;

   localparam int CB_EN    = 0;
   localparam int CB_EVRST = 1;
   localparam int CB_CYRST = 2;
   localparam int CB_LONG  = 7;
   localparam int CB_NLSB  = 11;
   localparam int CTRL_W   = 16;

   typedef enum logic [1:0] {
      SRC_NONE  = 2'd0,
      SRC_SW    = 2'd1,
      SRC_CHAIN = 2'd2,
      SRC_EXT   = 2'd3
   } evp_src_e;
endpackage

// File: rtl/evp_ctrl.sv
module evp_ctrl
   import evp_pkg::*;
#(
   parameter int NUM_CNT = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_ctrl,
   input  logic [CTRL_W-1:0] wdata,
   output logic [CTRL_W-1:0] ctrl_rd,
   output logic              glob_en,
   output logic              long_mode,
   output logic              cnt_clr
);
   localparam logic [7:0] PULSE_MASK = 8'((1 << CB_EVRST) | (1 << CB_CYRST));
   localparam logic [4:0] NFIELD     = 5'(NUM_CNT);

   logic [7:0] ctrl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (wr_ctrl) begin
         ctrl_q <= wdata[7:0] & ~PULSE_MASK;
      end
   end

   assign cnt_clr   = wr_ctrl & wdata[CB_EVRST];
   assign glob_en   = ctrl_q[CB_EN];
   assign long_mode = ctrl_q[CB_LONG];
   assign ctrl_rd   = {NFIELD, 3'b000, ctrl_q};
endmodule

// File: rtl/evp_bitreg.sv
module evp_bitreg #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_we,
   input  logic         clr_we,
   input  logic [W-1:0] bits,
   input  logic [W-1:0] hw_set,
   output logic [W-1:0] q
);
   logic [W-1:0] set_m;
   logic [W-1:0] clr_m;

   assign set_m = set_we ? bits : '0;
   assign clr_m = clr_we ? bits : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else begin
         q <= (q & ~clr_m) | set_m | hw_set;
      end
   end
endmodule

// File: rtl/evp_counter.sv
module evp_counter #(
   parameter int CNT_W = 64,
   parameter int LOW_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             we,
   input  logic [CNT_W-1:0] wdata,
   input  logic             inc,
   input  logic             long_mode,
   output logic [CNT_W-1:0] q,
   output logic             ovf
);
   logic at_wrap;

   generate
      if (LOW_W < CNT_W) begin : g_split
         logic low_ones;
         logic all_ones;
         assign low_ones = &q[LOW_W-1:0];
         assign all_ones = &q;
         assign at_wrap  = long_mode ? all_ones : low_ones;
      end else begin : g_full
         logic unused_mode;
         assign unused_mode = long_mode;
         assign at_wrap     = &q;
      end
   endgenerate

   assign ovf = inc & ~we & ~clr & at_wrap;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= '0;
      end else if (clr) begin
         q <= '0;
      end else if (we) begin
         q <= wdata;
      end else if (inc) begin
         q <= q + CNT_W'(1);
      end
   end
endmodule

// File: rtl/evp_pair_pmu.sv
module evp_pair_pmu
   import evp_pkg::*;
#(
   parameter int NUM_CNT = 2,
   parameter int CNT_W   = 64,
   parameter int LOW_W   = 32,
   parameter int TYPE_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_AW-1:0] wr_addr,
   input  logic [CNT_W-1:0]  wr_data,
   input  logic [REG_AW-1:0] rd_addr,
   output logic [CNT_W-1:0]  rd_data,
   input  logic [NUM_CNT-1:0] ev_pulse,
   output logic              irq
);
   generate
      if (NUM_CNT < 2 || NUM_CNT > MAX_CNT || (NUM_CNT % 2) != 0) begin : g_bad_n
         $error("NUM_CNT must be 2 or 4");
      end
      if (LOW_W < 1 || LOW_W > CNT_W || CNT_W < CTRL_W) begin : g_bad_w
         $error("counter widths out of range");
      end
      if (TYPE_W != 8) begin : g_bad_t
         $error("TYPE_W must be 8");
      end
   endgenerate

   logic [CTRL_W-1:0]  ctrl_rd;
   logic               glob_en;
   logic               long_mode;
   logic               cnt_clr;
   logic [NUM_CNT-1:0] en_q;
   logic [NUM_CNT-1:0] inten_q;
   logic [NUM_CNT-1:0] ovs_q;
   logic [NUM_CNT-1:0] ovf;
   logic [NUM_CNT-1:0] inc;
   logic [NUM_CNT-1:0] sw_hit;
   logic [NUM_CNT-1:0] chain_ev;
   logic [CNT_W-1:0]   cnt_q [NUM_CNT];
   logic [TYPE_W-1:0]  typ_q [NUM_CNT];
   logic               wr_ctrl;
   logic               wr_swinc;

   assign wr_ctrl  = wr_en && (wr_addr == A_CTRL);
   assign wr_swinc = wr_en && (wr_addr == A_SWINC);
   assign sw_hit   = wr_swinc ? wr_data[NUM_CNT-1:0] : '0;

   evp_ctrl #(.NUM_CNT(NUM_CNT)) i_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_ctrl   (wr_ctrl),
      .wdata     (wr_data[CTRL_W-1:0]),
      .ctrl_rd   (ctrl_rd),
      .glob_en   (glob_en),
      .long_mode (long_mode),
      .cnt_clr   (cnt_clr)
   );

   evp_bitreg #(.W(NUM_CNT)) i_en (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_en && (wr_addr == A_ENSET)),
      .clr_we (wr_en && (wr_addr == A_ENCLR)),
      .bits   (wr_data[NUM_CNT-1:0]),
      .hw_set ('0),
      .q      (en_q)
   );

   evp_bitreg #(.W(NUM_CNT)) i_inten (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (wr_en && (wr_addr == A_INTSET)),
      .clr_we (wr_en && (wr_addr == A_INTCLR)),
      .bits   (wr_data[NUM_CNT-1:0]),
      .hw_set ('0),
      .q      (inten_q)
   );

   evp_bitreg #(.W(NUM_CNT)) i_ovs (
      .clk    (clk),
      .rst_n  (rst_n),
      .set_we (1'b0),
      .clr_we (wr_en && (wr_addr == A_OVS)),
      .bits   (wr_data[NUM_CNT-1:0]),
      .hw_set (ovf),
      .q      (ovs_q)
   );

   for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
      localparam logic [REG_AW-1:0] CNT_ADDR = A_CNT0 + REG_AW'(i);
      localparam logic [REG_AW-1:0] TYP_ADDR = A_TYP0 + REG_AW'(i);
      evp_src_e src;
      logic     src_hit;

      if ((i % 2) == 1) begin : g_odd
         assign chain_ev[i] = ovf[i-1] & ~long_mode;
      end else begin : g_even
         assign chain_ev[i] = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            typ_q[i] <= '0;
         end else if (wr_en && (wr_addr == TYP_ADDR)) begin
            typ_q[i] <= wr_data[TYPE_W-1:0];
         end
      end

      always_comb begin
         unique case (typ_q[i])
            EV_SWINC: src = SRC_SW;
            EV_CHAIN: src = SRC_CHAIN;
            EV_EXT:   src = SRC_EXT;
            default:  src = SRC_NONE;
         endcase
      end

      always_comb begin
         unique case (src)
            SRC_SW:    src_hit = sw_hit[i];
            SRC_CHAIN: src_hit = chain_ev[i];
            SRC_EXT:   src_hit = ev_pulse[i];
            default:   src_hit = 1'b0;
         endcase
      end

      assign inc[i] = glob_en & en_q[i] & src_hit;

      evp_counter #(.CNT_W(CNT_W), .LOW_W(LOW_W)) i_counter (
         .clk       (clk),
         .rst_n     (rst_n),
         .clr       (cnt_clr),
         .we        (wr_en && (wr_addr == CNT_ADDR)),
         .wdata     (wr_data),
         .inc       (inc[i]),
         .long_mode (long_mode),
         .q         (cnt_q[i]),
         .ovf       (ovf[i])
      );
   end

   assign irq = |(ovs_q & inten_q);

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         A_CTRL:            rd_data = CNT_W'(ctrl_rd);
         A_ENSET, A_ENCLR:  rd_data = CNT_W'(en_q);
         A_OVS:             rd_data = CNT_W'(ovs_q);
         A_INTSET, A_INTCLR: rd_data = CNT_W'(inten_q);
         default: begin
            for (int k = 0; k < NUM_CNT; k++) begin
               if (rd_addr == A_CNT0 + REG_AW'(k)) rd_data = cnt_q[k];
               if (rd_addr == A_TYP0 + REG_AW'(k)) rd_data = CNT_W'(typ_q[k]);
            end
         end
      endcase
   end
endmodule

// File: rtl/evp_checker.sv
module evp_checker
   import evp_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int TYPE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_en,
   input logic [REG_AW-1:0] wr_addr,
   input logic [CNT_W-1:0]  wr_data,
   input logic [CNT_W-1:0]  cnt0,
   input logic [CNT_W-1:0]  cnt1,
   input logic [TYPE_W-1:0] typ1,
   input logic              long_mode,
   input logic              glob_en,
   input logic [1:0]        ovs,
   input logic              irq
);
   logic touch_c1;
   assign touch_c1 = wr_en && ((wr_addr == A_CNT0 + 4'd1) ||
                     ((wr_addr == A_CTRL) && wr_data[CB_EVRST]));

   AST_CNT_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_CNT0) |=> (cnt0 == $past(wr_data))); // R12

   AST_LONG_NO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (long_mode && typ1 == EV_CHAIN && !touch_c1) |=> $stable(cnt1)); // R7

   AST_HALT_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !wr_en) |=> ($stable(cnt0) && $stable(cnt1))); // R3

   AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !(wr_en && (wr_addr == A_OVS || wr_addr == A_INTCLR))) |=> irq); // R9

   AST_OVS0_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovs[0] && !(wr_en && wr_addr == A_OVS && wr_data[0])) |=> ovs[0]); // R8

   AST_OVS1_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovs[1] && !(wr_en && wr_addr == A_OVS && wr_data[1])) |=> ovs[1]); // R8
endmodule

bind evp_pair_pmu evp_checker #(.CNT_W(CNT_W), .TYPE_W(TYPE_W)) i_evp_checker (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_en     (wr_en),
   .wr_addr   (wr_addr),
   .wr_data   (wr_data),
   .cnt0      (cnt_q[0]),
   .cnt1      (cnt_q[1]),
   .typ1      (typ_q[1]),
   .long_mode (long_mode),
   .glob_en   (glob_en),
   .ovs       (ovs_q[1:0]),
   .irq       (irq)
);

// File: tb/test_evp_pair_pmu.sv
module test_evp_pair_pmu;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [3:0]  wr_addr = '0;
   logic [63:0] wr_data = '0;
   logic [3:0]  rd_addr = '0;
   logic [63:0] rd_data;
   logic [1:0]  ev_pulse = '0;
   logic        irq;

   int tests = 0;
   int fails = 0;

   always #10 clk = ~clk;

   evp_pair_pmu i_evp_pair_pmu (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .ev_pulse (ev_pulse),
      .irq      (irq)
   );

   typedef struct packed {
      logic        lng;
      logic [63:0] p0;
      logic [63:0] p1;
      logic [7:0]  t1;
      logic [63:0] e0;
      logic [63:0] e1;
      logic [1:0]  eovs;
   } vec_t;

   localparam int NV = 6;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 64'hFFFF_FFF0, 64'h1,         8'h1E, 64'h1_0000_0004, 64'h2,           2'b01},
      '{1'b0, 64'hFFFF_FFF0, 64'hFFFF_FFFF, 8'h1E, 64'h1_0000_0004, 64'h1_0000_0000, 2'b11},
      '{1'b1, 64'hFFFF_FFFF_FFFF_FFF0, 64'hFFFF_FFFF, 8'h1E, 64'h4, 64'hFFFF_FFFF, 2'b01},
      '{1'b1, 64'hFFFF_FFF0, 64'h5,         8'h1E, 64'h1_0000_0004, 64'h5,           2'b00},
      '{1'b0, 64'h10,        64'h7,         8'h13, 64'h24,          64'h7,           2'b00},
      '{1'b0, 64'hFFFF_FFF0, 64'h3,         8'h55, 64'h1_0000_0004, 64'h3,           2'b01}
   };

   task automatic wr(input logic [3:0] a, input logic [63:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output logic [63:0] d);
      rd_addr = a;
      #1;
      d = rd_data;
   endtask

   task automatic pulses(input int n);
      for (int p = 0; p < n; p++) begin
         @(negedge clk); ev_pulse = 2'b01;
         @(negedge clk); ev_pulse = 2'b00;
      end
   endtask

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [63:0] v;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd(4'd0, v);  check("R1 ctrl reset", v, 64'h1000);
      rd(4'd8, v);  check("R1 cnt0 reset", v, 64'h0);
      rd(4'd13, v); check("R1 typ1 reset", v, 64'h0);
      rd(4'd3, v);  check("R8 ovs reset", v, 64'h0);
      check("R9 irq reset", {63'd0, irq}, 64'h0);

      // Vector table: R4 R5 R6 R7 R11
      for (int i = 0; i < NV; i++) begin
         wr(4'd3, 64'h3);
         wr(4'd0, 64'h1 | (64'(VECS[i].lng) << 7));
         wr(4'd8, VECS[i].p0);
         wr(4'd9, VECS[i].p1);
         wr(4'd12, 64'h13);
         wr(4'd13, 64'(VECS[i].t1));
         wr(4'd1, 64'h3);
         pulses(20);
         rd(4'd8, v); check($sformatf("R4/R5 vec%0d cnt0", i), v, VECS[i].e0);
         rd(4'd9, v); check($sformatf("R6/R7/R11 vec%0d cnt1", i), v, VECS[i].e1);
         rd(4'd3, v); check($sformatf("R8 vec%0d ovs", i), v, 64'(VECS[i].eovs));
      end

      // R2 one-shot control bits, R1 read-only count field
      wr(4'd0, 64'hF8F7);
      rd(4'd0, v); check("R2 ctrl readback", v, 64'h10F1);
      rd(4'd8, v); check("R2 cnt0 cleared", v, 64'h0);
      rd(4'd9, v); check("R2 cnt1 cleared", v, 64'h0);

      // R10 software increment gating
      wr(4'd0, 64'h0);
      wr(4'd12, 64'h00);
      wr(4'd13, 64'h13);
      wr(4'd8, 64'd10);
      wr(4'd9, 64'd10);
      wr(4'd1, 64'h3);
      for (int k = 0; k < 5; k++) wr(4'd6, 64'h3);
      rd(4'd8, v); check("R10 swinc ignored when disabled", v, 64'd10);
      wr(4'd0, 64'h1);
      for (int k = 0; k < 5; k++) wr(4'd6, 64'h3);
      rd(4'd8, v); check("R10 swinc counts", v, 64'd15);
      rd(4'd9, v); check("R10 swinc needs sw type", v, 64'd10);

      // R3 per-counter enable
      wr(4'd2, 64'h1);
      rd(4'd1, v); check("R3 enable mask", v, 64'h2);
      for (int k = 0; k < 3; k++) wr(4'd6, 64'h1);
      rd(4'd8, v); check("R3 disabled counter holds", v, 64'd15);

      // R4 exact boundary, R8 sticky, R9 interrupt
      wr(4'd1, 64'h1);
      wr(4'd12, 64'h13);
      wr(4'd3, 64'h3);
      wr(4'd8, 64'hFFFF_FFFE);
      pulses(1);
      rd(4'd3, v); check("R4 no ovf before wrap", v, 64'h0);
      pulses(1);
      rd(4'd3, v); check("R4 ovf at 32-bit wrap", v, 64'h1);
      rd(4'd8, v); check("R4 upper bits carry", v, 64'h1_0000_0000);
      check("R9 irq masked", {63'd0, irq}, 64'h0);
      wr(4'd4, 64'h1);
      check("R9 irq raised", {63'd0, irq}, 64'h1);
      wr(4'd3, 64'h0);
      rd(4'd3, v); check("R8 write 0 keeps status", v, 64'h1);
      check("R9 irq level holds", {63'd0, irq}, 64'h1);
      wr(4'd3, 64'h1);
      rd(4'd3, v); check("R8 write 1 clears", v, 64'h0);
      check("R9 irq drops", {63'd0, irq}, 64'h0);

      // R12 write beats increment
      wr(4'd8, 64'd100);
      @(negedge clk);
      ev_pulse = 2'b01; wr_en = 1'b1; wr_addr = 4'd8; wr_data = 64'd500;
      @(negedge clk);
      ev_pulse = 2'b00; wr_en = 1'b0;
      rd(4'd8, v); check("R12 write priority", v, 64'd500);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule